// File: doc/BRIEF.md
# Gated 13/16-bit counter/timer

This block is one counter/timer channel of a small microcontroller-style peripheral set. Its count lives in a low byte and a high byte. It counts in one of two widths: a 13-bit width, where only the bottom five bits of the low byte take part, or a full 16-bit width. Each count step comes from one of three sources. The sources are every system clock, a prescaled clock-enable strobe supplied from outside, or falling edges on an external count pin. Every configuration field arrives as a plain input port.

Counting can be left under the run bit alone. It can also be gated in hardware by an external gate pin whose active level is programmable. Holding the run bit high while the gate pin frames a pulse makes the count equal the pulse width in ticks. Software presets the count through two byte-load strobes. Setting the run bit continues from whatever value is loaded. A sticky flag records each rollover and stays set until a clear strobe arrives.

Top module: `gated_tick_counter`

## Requirements
- R1: While reset is asserted and after its release, `cnt_lo`, `cnt_hi` and `ovf_flag` are all zero until something loads or counts.
- R2: With `ext_sel`=0 and `fast_sel`=1, the count advances by one on every clock edge at which counting is enabled.
- R3: With `ext_sel`=0 and `fast_sel`=0, the count advances by one only on clock edges where `prescale_tick` is 1.
- R4: With `ext_sel`=1, each high-to-low transition of `count_pin` advances the count exactly once, and `fast_sel` has no effect. Rising edges and steady levels do not count. The count changes on the third clock edge after the pin changes, because of two synchroniser flops and one edge register.
- R5: When `run_en` is 0, the count does not change.
- R6: When `gate_en` is 1, counting needs the synchronised gate pin to be active. `gate_pol`=0 makes a low level active and `gate_pol`=1 makes a high level active. When `gate_en` is 0, the gate pin is ignored.
- R7: Setting `run_en` does not clear the count. Counting resumes from the loaded value.
- R8: With `wide_mode`=0, the count is 13 bits wide. It is formed by `cnt_hi` above `cnt_lo[4:0]`. A carry out of `cnt_lo[4:0]` increments `cnt_hi`. Counting leaves `cnt_lo[7:5]` unchanged. The count wraps from 0x1FFF to 0 and sets `ovf_flag`.
- R9: With `wide_mode`=1, the count is `{cnt_hi, cnt_lo}`. It wraps from 0xFFFF to 0 and sets `ovf_flag`.
- R10: `ovf_flag` stays set until an `ovf_clr` strobe clears it on the next edge. When a clear and a rollover happen in the same cycle, the flag stays set.
- R11: `ld_lo` writes `ld_data` into `cnt_lo` and `ld_hi` writes `ld_data` into `cnt_hi` on the next edge. A cycle with any load strobe high does not count, and a byte that is not being loaded keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run bit |
| gate_en | input | 1 | 1: counting also needs the gate pin to be active |
| gate_pol | input | 1 | Active level of the gate pin (0 low, 1 high) |
| gate_pin | input | 1 | External gate pin, asynchronous |
| ext_sel | input | 1 | 1: count falling edges of `count_pin` |
| fast_sel | input | 1 | With `ext_sel`=0: 1 selects every clock, 0 selects `prescale_tick` |
| prescale_tick | input | 1 | Prescaled clock-enable strobe |
| count_pin | input | 1 | External count pin, asynchronous |
| wide_mode | input | 1 | 0: 13-bit count, 1: 16-bit count |
| ld_lo | input | 1 | Load strobe for the low byte |
| ld_hi | input | 1 | Load strobe for the high byte |
| ld_data | input | 8 | Load value |
| ovf_clr | input | 1 | Clear strobe for the rollover flag |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky rollover flag |

## Verification
The bench builds the block with its default parameters: two synchroniser stages, 8-bit bytes and a 5-bit short low field. With these values, byte loads put the 13-bit rollover at 0x1FFF and the 16-bit rollover at 0xFFFF a few ticks away. The three-edge latency from the count pin to the count then falls on a fixed cycle that the bench can sample exactly. The 13-bit rows use low bytes with non-zero upper bits, so a design that lets the top three bits move or carries from the wrong bit position shows up in the bytes read back.

// File: rtl/gtc_pkg.sv
package gtc_pkg;

  // Where a count step comes from
  typedef enum logic [1:0] {
    SRC_PRESCALED = 2'd0,
    SRC_SYSTEM    = 2'd1,
    SRC_PIN       = 2'd2
  } tick_src_e;

  // Counter/timer select wins over the clock-select bit
  function automatic tick_src_e pick_source(input logic ext_sel, input logic fast_sel);
    if (ext_sel)       return SRC_PIN;
    else if (fast_sel) return SRC_SYSTEM;
    else               return SRC_PRESCALED;
  endfunction

  // The gate is open when the pin level matches the programmed polarity
  function automatic logic gate_is_open(input logic level, input logic pol);
    return ~(level ^ pol);
  endfunction

endpackage

// File: rtl/gtc_sync.sv
module gtc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= 1'b0;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gtc_tick_gen.sv
module gtc_tick_gen
  import gtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic gate_en,
  input  logic gate_pol,
  input  logic gate_sync,
  input  logic pin_sync,
  input  logic ext_sel,
  input  logic fast_sel,
  input  logic prescale_tick,
  output logic pin_fall,
  output logic run_ok,
  output logic tick
);

  logic      pin_prev;
  logic      src_tick;
  tick_src_e src;

  // Previous synchronised sample: one fall per transition
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= 1'b0;
    else        pin_prev <= pin_sync;
  end

  assign pin_fall = pin_prev & ~pin_sync;
  assign run_ok   = run_en & (~gate_en | gate_is_open(gate_sync, gate_pol));
  assign src      = pick_source(ext_sel, fast_sel);

  always_comb begin
    unique case (src)
      SRC_PIN:    src_tick = pin_fall;
      SRC_SYSTEM: src_tick = 1'b1;
      default:    src_tick = prescale_tick;
    endcase
  end

  assign tick = run_ok & src_tick;

endmodule

// File: rtl/gtc_count_core.sv
module gtc_count_core #(
  parameter int BYTE_W  = 8,
  parameter int SHORT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wide_mode,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [BYTE_W-1:0] ld_data,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              wrap
);

  localparam int PAIR_W = 2 * BYTE_W;

  // Returns {carry_out, next_hi, next_lo}
  function automatic logic [PAIR_W:0] advance(input logic [BYTE_W-1:0] hi,
                                              input logic [BYTE_W-1:0] lo,
                                              input logic              wide);
    logic [BYTE_W:0]     l_sum;
    logic [SHORT_W:0]    s_sum;
    logic [BYTE_W:0]     h_sum;
    logic [BYTE_W-1:0]   lo_out;
    if (wide) begin
      l_sum  = {1'b0, lo} + (BYTE_W+1)'(1);
      h_sum  = {1'b0, hi} + (BYTE_W+1)'(l_sum[BYTE_W]);
      lo_out = l_sum[BYTE_W-1:0];
    end else begin
      s_sum  = {1'b0, lo[SHORT_W-1:0]} + (SHORT_W+1)'(1);
      h_sum  = {1'b0, hi} + (BYTE_W+1)'(s_sum[SHORT_W]);
      lo_out = {lo[BYTE_W-1:SHORT_W], s_sum[SHORT_W-1:0]};
    end
    return {h_sum[BYTE_W], h_sum[BYTE_W-1:0], lo_out};
  endfunction

  logic [BYTE_W-1:0] lo_n, hi_n;
  logic [PAIR_W:0]   step;

  assign step = advance(cnt_hi, cnt_lo, wide_mode);

  // Any load strobe takes the whole cycle; the count step is dropped
  always_comb begin
    lo_n = cnt_lo;
    hi_n = cnt_hi;
    wrap = 1'b0;
    if (ld_lo || ld_hi) begin
      if (ld_lo) lo_n = ld_data;
      if (ld_hi) hi_n = ld_data;
    end else if (tick) begin
      lo_n = step[BYTE_W-1:0];
      hi_n = step[PAIR_W-1:BYTE_W];
      wrap = step[PAIR_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= lo_n;
      cnt_hi <= hi_n;
    end
  end

endmodule

// File: rtl/gtc_ovf_flag.sv
module gtc_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic clr,
  output logic flag
);

  // A rollover in the clear cycle keeps the flag set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (wrap) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end

endmodule

// File: rtl/gated_tick_counter.sv
module gated_tick_counter #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int SHORT_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              gate_en,
  input  logic              gate_pol,
  input  logic              gate_pin,
  input  logic              ext_sel,
  input  logic              fast_sel,
  input  logic              prescale_tick,
  input  logic              count_pin,
  input  logic              wide_mode,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic [BYTE_W-1:0] ld_data,
  input  logic              ovf_clr,
  output logic [BYTE_W-1:0] cnt_lo,
  output logic [BYTE_W-1:0] cnt_hi,
  output logic              ovf_flag
);

  localparam int N_PINS = 2;

  logic [N_PINS-1:0] raw_pins, sync_pins;
  logic pin_fall, run_ok, tick, wrap;

  assign raw_pins = {gate_pin, count_pin};

  for (genvar p = 0; p < N_PINS; p++) begin : g_pin_sync
    gtc_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_pins[p]),
      .q     (sync_pins[p])
    );
  end

  gtc_tick_gen i_tick_gen (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_en        (run_en),
    .gate_en       (gate_en),
    .gate_pol      (gate_pol),
    .gate_sync     (sync_pins[1]),
    .pin_sync      (sync_pins[0]),
    .ext_sel       (ext_sel),
    .fast_sel      (fast_sel),
    .prescale_tick (prescale_tick),
    .pin_fall      (pin_fall),
    .run_ok        (run_ok),
    .tick          (tick)
  );

  gtc_count_core #(.BYTE_W(BYTE_W), .SHORT_W(SHORT_W)) i_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wide_mode (wide_mode),
    .ld_lo     (ld_lo),
    .ld_hi     (ld_hi),
    .ld_data   (ld_data),
    .cnt_lo    (cnt_lo),
    .cnt_hi    (cnt_hi),
    .wrap      (wrap)
  );

  gtc_ovf_flag i_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .wrap  (wrap),
    .clr   (ovf_clr),
    .flag  (ovf_flag)
  );

endmodule

// File: rtl/gtc_checker.sv
module gtc_checker #(
  parameter int BYTE_W  = 8,
  parameter int SHORT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              ext_sel,
  input logic              fast_sel,
  input logic              wide_mode,
  input logic              ld_lo,
  input logic              ld_hi,
  input logic [BYTE_W-1:0] ld_data,
  input logic              ovf_clr,
  input logic [BYTE_W-1:0] cnt_lo,
  input logic [BYTE_W-1:0] cnt_hi,
  input logic              ovf_flag,
  input logic              run_ok,
  input logic              wrap
);

  logic no_load;
  assign no_load = !ld_lo && !ld_hi;

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && no_load) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  p_gate_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_ok && no_load) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  p_sys_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ok && !ext_sel && fast_sel && wide_mode && no_load)
      |=> ({cnt_hi, cnt_lo} == $past({cnt_hi, cnt_lo}) + 1'b1));

  p_upper_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && !ld_lo) |=> (cnt_lo[BYTE_W-1:SHORT_W] == $past(cnt_lo[BYTE_W-1:SHORT_W])));

  p_wrap_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (ovf_flag && cnt_hi == '0 && cnt_lo[SHORT_W-1:0] == '0));

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !wrap) |=> !ovf_flag);

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag && !wrap) |=> !ovf_flag);

  p_load_lo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> (cnt_lo == $past(ld_data)));

  p_load_hi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> (cnt_hi == $past(ld_data)));

endmodule

bind gated_tick_counter gtc_checker #(.BYTE_W(BYTE_W), .SHORT_W(SHORT_W)) i_gtc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .ext_sel   (ext_sel),
  .fast_sel  (fast_sel),
  .wide_mode (wide_mode),
  .ld_lo     (ld_lo),
  .ld_hi     (ld_hi),
  .ld_data   (ld_data),
  .ovf_clr   (ovf_clr),
  .cnt_lo    (cnt_lo),
  .cnt_hi    (cnt_hi),
  .ovf_flag  (ovf_flag),
  .run_ok    (run_ok),
  .wrap      (wrap)
);

// File: tb/test_gated_tick_counter.sv
module test_gated_tick_counter;

  logic clk = 1'b0;
  logic rst_n, run_en, gate_en, gate_pol, gate_pin, ext_sel, fast_sel;
  logic prescale_tick, count_pin, wide_mode, ld_lo, ld_hi, ovf_clr;
  logic [7:0] ld_data, cnt_lo, cnt_hi;
  logic ovf_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gated_tick_counter i_gated_tick_counter (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .gate_en(gate_en),
    .gate_pol(gate_pol), .gate_pin(gate_pin), .ext_sel(ext_sel),
    .fast_sel(fast_sel), .prescale_tick(prescale_tick), .count_pin(count_pin),
    .wide_mode(wide_mode), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_data(ld_data),
    .ovf_clr(ovf_clr), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag)
  );

  typedef struct packed {
    logic       wide;
    logic       fast;
    logic [3:0] every;
    logic       g_en;
    logic       pol;
    logic       pin;
    logic [7:0] s_hi;
    logic [7:0] s_lo;
    logic [7:0] n;
    logic [7:0] e_hi;
    logic [7:0] e_lo;
    logic       e_flag;
    logic [3:0] req;
  } row_t;

  localparam int NROWS = 12;
  localparam row_t ROWS [NROWS] = '{
    // wide fast every gen pol pin  s_hi   s_lo   n      e_hi   e_lo   flag req
    '{1'b1, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'd10, 8'h00, 8'h0A, 1'b0, 4'd2},  // R2
    '{1'b1, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFE, 8'd5,  8'h00, 8'h03, 1'b1, 4'd9},  // R9
    '{1'b0, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFD, 8'd4,  8'h00, 8'hE1, 1'b1, 4'd8},  // R8 wrap
    '{1'b0, 1'b1, 4'd1, 1'b0, 1'b0, 1'b0, 8'h12, 8'h5E, 8'd3,  8'h13, 8'h41, 1'b0, 4'd8},  // R8 carry
    '{1'b1, 1'b0, 4'd4, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'd10, 8'h00, 8'h03, 1'b0, 4'd3},  // R3
    '{1'b1, 1'b1, 4'd1, 1'b1, 1'b1, 1'b1, 8'h01, 8'h00, 8'd6,  8'h01, 8'h06, 1'b0, 4'd6},  // R6 open high
    '{1'b1, 1'b1, 4'd1, 1'b1, 1'b1, 1'b0, 8'h01, 8'h00, 8'd6,  8'h01, 8'h00, 1'b0, 4'd6},  // R6 shut
    '{1'b1, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 8'd2,  8'h01, 8'h01, 1'b0, 4'd6},  // R6 open low
    '{1'b1, 1'b1, 4'd1, 1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 8'd2,  8'h00, 8'hFF, 1'b0, 4'd6},  // R6 shut
    '{1'b1, 1'b1, 4'd1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h10, 8'd2,  8'h00, 8'h12, 1'b0, 4'd6},  // R6 gate off
    '{1'b0, 1'b0, 4'd2, 1'b0, 1'b0, 1'b0, 8'h00, 8'h1F, 8'd4,  8'h01, 8'h01, 1'b0, 4'd3},  // R3 13-bit
    '{1'b0, 1'b0, 4'd3, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'd7,  8'h00, 8'h03, 1'b0, 4'd3}   // R3, R7
  };

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic load(input logic [7:0] hi, input logic [7:0] lo);
    run_en = 1'b0;
    ld_hi = 1'b1; ld_data = hi; step(1);
    ld_hi = 1'b0; ld_lo = 1'b1; ld_data = lo; step(1);
    ld_lo = 1'b0;
  endtask

  task automatic clear_flag();
    ovf_clr = 1'b1; step(1);
    ovf_clr = 1'b0;
  endtask

  task automatic run_row(input row_t r, input int idx);
    ext_sel = 1'b0;
    wide_mode = r.wide; fast_sel = r.fast;
    gate_en = r.g_en; gate_pol = r.pol; gate_pin = r.pin;
    step(4);
    clear_flag();
    load(r.s_hi, r.s_lo);
    for (int i = 0; i < int'(r.n); i++) begin
      run_en = 1'b1;
      prescale_tick = ((i % int'(r.every)) == 0);
      step(1);
    end
    run_en = 1'b0; prescale_tick = 1'b0;
    step(1);
    check($sformatf("R%0d row %0d hi", r.req, idx), {8'h00, cnt_hi}, {8'h00, r.e_hi});
    check($sformatf("R%0d row %0d lo", r.req, idx), {8'h00, cnt_lo}, {8'h00, r.e_lo});
    check($sformatf("R%0d row %0d flag", r.req, idx), {15'd0, ovf_flag}, {15'd0, r.e_flag});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1..all actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run_en = 1'b0; gate_en = 1'b0; gate_pol = 1'b0; gate_pin = 1'b0;
    ext_sel = 1'b0; fast_sel = 1'b1; prescale_tick = 1'b0; count_pin = 1'b1;
    wide_mode = 1'b1; ld_lo = 1'b0; ld_hi = 1'b0; ld_data = 8'h00; ovf_clr = 1'b0;
    step(3);
    check("R1 reset count", {cnt_hi, cnt_lo}, 16'h0000);
    check("R1 reset flag", {15'd0, ovf_flag}, 16'd0);
    rst_n = 1'b1;
    step(3);
    check("R1 after release", {cnt_hi, cnt_lo}, 16'h0000);

    // Table walk: internal sources, gating, widths
    foreach (ROWS[k]) run_row(ROWS[k], k);

    // R5: run bit low, system clock selected
    load(8'h34, 8'h56);
    gate_en = 1'b0; ext_sel = 1'b0; fast_sel = 1'b1; wide_mode = 1'b1;
    run_en = 1'b0; step(5);
    check("R5 hold while stopped", {cnt_hi, cnt_lo}, 16'h3456);
    // R7: starting does not clear
    run_en = 1'b1; step(1); run_en = 1'b0;
    check("R7 resume from loaded value", {cnt_hi, cnt_lo}, 16'h3457);

    // R4: external count pin, latency and single count per fall
    load(8'h00, 8'h00);
    ext_sel = 1'b1; fast_sel = 1'b1; count_pin = 1'b1; run_en = 1'b1;
    step(4);
    check("R4 high level no count", {cnt_hi, cnt_lo}, 16'h0000);
    count_pin = 1'b0; step(2);
    check("R4 before third edge", {cnt_hi, cnt_lo}, 16'h0000);
    step(1);
    check("R4 at third edge", {cnt_hi, cnt_lo}, 16'h0001);
    step(4);
    check("R4 low level counts once", {cnt_hi, cnt_lo}, 16'h0001);
    for (int p = 0; p < 3; p++) begin
      count_pin = 1'b1; step(3);
      count_pin = 1'b0; step(3);
    end
    count_pin = 1'b1; step(6);
    check("R4 three more falls", {cnt_hi, cnt_lo}, 16'h0004);
    run_en = 1'b0; ext_sel = 1'b0;

    // R10: sticky flag, clear, and clear colliding with rollover
    clear_flag();
    load(8'hFF, 8'hFF);
    run_en = 1'b1; step(1); run_en = 1'b0;
    check("R9 16-bit wrap count", {cnt_hi, cnt_lo}, 16'h0000);
    step(5);
    check("R10 flag sticky", {15'd0, ovf_flag}, 16'd1);
    load(8'hFF, 8'hFF);
    run_en = 1'b1; ovf_clr = 1'b1; step(1);
    run_en = 1'b0; ovf_clr = 1'b0;
    check("R10 set beats clear", {15'd0, ovf_flag}, 16'd1);
    clear_flag();
    check("R10 clear strobe", {15'd0, ovf_flag}, 16'd0);
    step(3);
    check("R10 stays clear", {15'd0, ovf_flag}, 16'd0);

    // R11: load during a counting cycle wins; other byte holds
    load(8'h22, 8'h10);
    run_en = 1'b1; ld_lo = 1'b1; ld_data = 8'h40; step(1);
    ld_lo = 1'b0;
    check("R11 load beats tick lo", {8'h00, cnt_lo}, 16'h0040);
    check("R11 hi untouched", {8'h00, cnt_hi}, 16'h0022);
    step(1); run_en = 1'b0;
    check("R11 counting after load", {cnt_hi, cnt_lo}, 16'h2241);

    // R8: 13-bit load keeps upper bits, count leaves them alone
    wide_mode = 1'b0;
    load(8'h00, 8'hBF);
    run_en = 1'b1; step(1); run_en = 1'b0;
    check("R8 13-bit carry keeps upper bits", {cnt_hi, cnt_lo}, 16'h01A0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule